// File: doc/BRIEF.md
# Return Address Stack Predictor

This block supplies predicted targets for function returns at the fetch stage. It keeps a small circular stack of return addresses. When fetch flags a call, the address of the instruction that follows the call is pushed. That address is the call's fetch PC plus its instruction size. When fetch flags a return, the most recently pushed address is popped. In the same cycle, with no register in between, it is presented as the predicted next fetch address together with a valid flag.

Calls are always taken and have one known target, so they take no prediction from this block. Only returns read the stack. When more calls arrive than the stack can hold, the oldest entry is lost. A return that finds the stack empty produces no prediction. The stack is not repaired after mispredictions.

Top module: `ret_addr_stack`

## Requirements
- R1: A call pushes fetch PC plus the zero-extended instruction size, computed modulo 2^ADDR_W, so that PC 0xFFFFFFFE with size 4 pushes 0x00000002.
- R2: A return on a non-empty stack raises the valid output in the same cycle and drives the target output with the most recently pushed address that has not been popped.
- R3: Nested calls are returned in last-in, first-out order.
- R4: The stack holds DEPTH (default 8) entries. A push on a full stack overwrites the oldest entry and the depth stays at DEPTH, so after 10 calls the next 8 returns yield the newest 8 addresses and the 9th return is invalid.
- R5: A return on an empty stack drives valid low and target zero, and the stack stays empty, so a later call then return behaves normally.
- R6: Call and return in the same cycle on a non-empty stack output the old top as the prediction. The new return address then replaces the top entry, and the depth is unchanged.
- R7: Call and return in the same cycle on an empty stack give no valid prediction and leave exactly one entry, the new return address.
- R8: Whenever the return input is low, valid is low and the target output is zero. Calls alone produce no prediction.
- R9: Reset (rst_n low, synchronous) empties the stack, so the first return after reset is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Fetch reports a call this cycle |
| ret_i | input | 1 | Fetch reports a return this cycle |
| fetch_pc_i | input | ADDR_W | PC of the reported instruction |
| inst_size_i | input | SIZE_W | Size in bytes of the reported instruction |
| pred_target_o | output | ADDR_W | Predicted return target, zero when not valid |
| pred_valid_o | output | 1 | Predicted target is valid |

## Verification
A push and a pop can fall in the same cycle when fetch reports a call and a return together. The ordering rule, pop then push, decides what that cycle predicts and what the stack holds afterwards. The bench provokes this case on a stack holding several entries, on an empty stack and on a full stack, and also mixes it into a long random stream of calls and returns. It judges the case by the prediction in that cycle and by the sequence of targets that later returns unwind, both compared with a queue model.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Effective stack operation for one cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;

  // A pop only counts when the stack holds something.
  function automatic ras_op_e decode_op(input logic call, input logic pop_ok);
    ras_op_e op;
    case ({call, pop_ok})
      2'b10:   op = OP_PUSH;
      2'b01:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/ras_tos_ctrl.sv
module ras_tos_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ras_pkg::ras_op_e     op,
  output logic [PTR_W-1:0]     tos_o,
  output logic [CNT_W-1:0]     depth_o,
  output logic [PTR_W-1:0]     wr_idx_o,
  output logic                 wr_en_o
);
  import ras_pkg::*;

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] tos_q, tos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tos_d    = tos_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = ptr_inc(tos_q);
    case (op)
      OP_PUSH: begin
        tos_d    = ptr_inc(tos_q);
        cnt_d    = (cnt_q == FULL_CNT) ? cnt_q : cnt_q + 1'b1;
        wr_en_o  = 1'b1;
        wr_idx_o = ptr_inc(tos_q);
      end
      OP_POP: begin
        tos_d = ptr_dec(tos_q);
        cnt_d = cnt_q - 1'b1;
      end
      OP_SWAP: begin
        wr_en_o  = 1'b1;
        wr_idx_o = tos_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos_q <= LAST_IDX;
      cnt_q <= '0;
    end else begin
      tos_q <= tos_d;
      cnt_q <= cnt_d;
    end
  end

  assign tos_o   = tos_q;
  assign depth_o = cnt_q;

endmodule

// File: rtl/ras_entry_file.sv
module ras_entry_file #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);

  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == PTR_W'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic [SIZE_W-1:0] inst_size_i,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic              pred_valid_o
);
  import ras_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [ADDR_W-1:0] next_seq(input logic [ADDR_W-1:0] pc,
                                                 input logic [SIZE_W-1:0] sz);
    return pc + ADDR_W'(sz);
  endfunction

  logic [PTR_W-1:0]  tos;
  logic [CNT_W-1:0]  depth;
  logic [PTR_W-1:0]  wr_idx;
  logic              wr_en;
  logic [ADDR_W-1:0] top_addr;
  logic [ADDR_W-1:0] push_addr;
  ras_op_e           op;

  // Named events for the checker.
  logic stack_empty, stack_full, pop_evt, underflow_evt, overflow_evt, swap_evt;

  assign stack_empty   = (depth == '0);
  assign stack_full    = (depth == CNT_W'(DEPTH));
  assign pop_evt       = ret_i && !stack_empty;
  assign underflow_evt = ret_i && stack_empty;
  assign op            = decode_op(call_i, pop_evt);
  assign overflow_evt  = (op == OP_PUSH) && stack_full;
  assign swap_evt      = (op == OP_SWAP);
  assign push_addr     = next_seq(fetch_pc_i, inst_size_i);

  ras_tos_ctrl #(.DEPTH(DEPTH)) u_tos (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .tos_o    (tos),
    .depth_o  (depth),
    .wr_idx_o (wr_idx),
    .wr_en_o  (wr_en)
  );

  ras_entry_file #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (push_addr),
    .rd_idx  (tos),
    .rd_data (top_addr)
  );

  assign pred_valid_o  = pop_evt;
  assign pred_target_o = pop_evt ? top_addr : '0;

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic [ADDR_W-1:0] fetch_pc_i,
  input logic [SIZE_W-1:0] inst_size_i,
  input logic [ADDR_W-1:0] pred_target_o,
  input logic              pred_valid_o,
  input logic [CNT_W-1:0]  depth,
  input logic              underflow_evt,
  input logic              overflow_evt
);

  logic [ADDR_W-1:0] seq_addr;
  assign seq_addr = fetch_pc_i + ADDR_W'(inst_size_i);

  // R8
  valid_needs_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_o |-> ret_i);

  // R5
  underflow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |-> (!pred_valid_o && pred_target_o == '0));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  // R4
  overflow_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |=> (depth == CNT_W'(DEPTH)));

  // R6
  swap_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i && depth != '0) |=> $stable(depth));

  // R7
  empty_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i && depth == '0) |=> (depth == CNT_W'(1)));

  // R1
  push_pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i ##1 ret_i) |-> (pred_valid_o && pred_target_o == $past(seq_addr)));

endmodule

bind ret_addr_stack ras_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .call_i        (call_i),
  .ret_i         (ret_i),
  .fetch_pc_i    (fetch_pc_i),
  .inst_size_i   (inst_size_i),
  .pred_target_o (pred_target_o),
  .pred_valid_o  (pred_valid_o),
  .depth         (depth),
  .underflow_evt (underflow_evt),
  .overflow_evt  (overflow_evt)
);

// File: tb/sim_ret_addr_stack.sv
`timescale 1ns/1ps
module sim_ret_addr_stack;
  localparam int AW = 32;
  localparam int SW = 3;
  localparam int DP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_i = 1'b0;
  logic          ret_i = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0;
  logic [SW-1:0] inst_size_i = '0;
  logic [AW-1:0] pred_target_o;
  logic          pred_valid_o;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] model_q[$];

  always #5 clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .SIZE_W(SW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .fetch_pc_i(fetch_pc_i), .inst_size_i(inst_size_i),
    .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] got_t, input logic got_v,
                       input logic [AW-1:0] exp_t, input logic exp_v);
    total++;
    if (got_v !== exp_v || got_t !== exp_t) begin
      bad++;
      $display("FAIL %s: valid=%0b target=%h expected valid=%0b target=%h",
               tag, got_v, got_t, exp_v, exp_t);
    end
  endtask

  // Drive one cycle after the falling edge, compare, then advance the model.
  task automatic step(input string tag, input logic c, input logic r,
                      input logic [AW-1:0] pc, input logic [SW-1:0] sz);
    logic          ev;
    logic [AW-1:0] et;
    @(negedge clk);
    call_i = c; ret_i = r; fetch_pc_i = pc; inst_size_i = sz;
    #1;
    ev = r && (model_q.size() > 0);
    et = ev ? model_q[$] : '0;
    check(tag, pred_target_o, pred_valid_o, et, ev);
    if (ev) void'(model_q.pop_back());
    if (c) begin
      model_q.push_back(pc + {{(AW-SW){1'b0}}, sz});
      if (model_q.size() > DP) void'(model_q.pop_front());
    end
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; call_i = 1'b0; ret_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_q.delete();
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R9: empty after reset
    step("R9", 1'b0, 1'b1, 32'h0, 3'd0);

    // R8: calls alone give no prediction
    step("R8", 1'b1, 1'b0, 32'h1000, 3'd4);
    step("R8", 1'b1, 1'b0, 32'h2000, 3'd2);
    step("R8", 1'b0, 1'b0, 32'h0, 3'd0);
    // R2: same-cycle prediction of the newest entry
    step("R2", 1'b0, 1'b1, 32'h0, 3'd0);
    step("R2", 1'b0, 1'b1, 32'h0, 3'd0);
    // R5: underflow
    step("R5", 1'b0, 1'b1, 32'h0, 3'd0);
    step("R5", 1'b0, 1'b1, 32'h0, 3'd0);
    step("R5", 1'b1, 1'b0, 32'h3000, 3'd4);
    step("R5", 1'b0, 1'b1, 32'h0, 3'd0);

    // R1: sizes and wrap
    step("R1", 1'b1, 1'b0, 32'hFFFF_FFFE, 3'd4);
    step("R1", 1'b0, 1'b1, 32'h0, 3'd0);
    step("R1", 1'b1, 1'b0, 32'h0000_4000, 3'd7);
    step("R1", 1'b0, 1'b1, 32'h0, 3'd0);

    // R3: nesting
    for (int i = 0; i < 5; i++) step("R3", 1'b1, 1'b0, 32'h5000 + 32'(i*16), 3'd4);
    for (int i = 0; i < 6; i++) step("R3", 1'b0, 1'b1, 32'h0, 3'd0);

    // R4: overflow
    for (int i = 0; i < 10; i++) step("R4", 1'b1, 1'b0, 32'h8000 + 32'(i*32), 3'd2);
    for (int i = 0; i < 9; i++) step("R4", 1'b0, 1'b1, 32'h0, 3'd0);

    // R6: call+return on non-empty, then unwind
    step("R6", 1'b1, 1'b0, 32'hA000, 3'd4);
    step("R6", 1'b1, 1'b0, 32'hA100, 3'd4);
    step("R6", 1'b1, 1'b1, 32'hA200, 3'd2);
    for (int i = 0; i < 3; i++) step("R6", 1'b0, 1'b1, 32'h0, 3'd0);
    // R6 on full stack
    for (int i = 0; i < DP; i++) step("R6", 1'b1, 1'b0, 32'hB000 + 32'(i*8), 3'd4);
    step("R6", 1'b1, 1'b1, 32'hBF00, 3'd4);
    for (int i = 0; i < DP + 1; i++) step("R6", 1'b0, 1'b1, 32'h0, 3'd0);

    // R7: call+return on empty
    step("R7", 1'b1, 1'b1, 32'hC000, 3'd4);
    step("R7", 1'b0, 1'b1, 32'h0, 3'd0);
    step("R7", 1'b0, 1'b1, 32'h0, 3'd0);

    // R9: reset mid-run
    step("R9", 1'b1, 1'b0, 32'hD000, 3'd4);
    do_reset();
    step("R9", 1'b0, 1'b1, 32'h0, 3'd0);

    // R3: random mix of calls, returns and both
    for (int i = 0; i < 400; i++) begin
      logic [1:0] k = 2'($urandom_range(0, 3));
      step("R3", k[0], k[1], $urandom(), 3'($urandom_range(0, 7)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule